// File: doc/BRIEF.md
# Coarse Single-Sprite Video Generator

This block produces the raster timing and pixel colour for an 800x600, 60 Hz display. It draws a plain background colour and one movable sprite on top of it. There is no frame store: each pixel's colour is worked out from the beam position while the beam scans. The picture is built on a coarse 100x75 grid. Each grid cell covers an 8x8 square of screen pixels, so the sprite (8x8 cells, one bit per cell) covers 64x64 screen pixels.

A single mode input picks between two clock rates. With the input low, the block runs from a 40 MHz clock and moves one screen pixel per clock. With the input high, it runs from a 10 MHz clock and moves four screen pixels per clock. Every horizontal interval keeps the same length measured in screen pixels.

A one-cycle write port sets the sprite bitmap, the two colours and the sprite position. A new position is held back until the next vertical blanking starts, so a frame never shows the sprite at two positions.

Top module: `sprite_video_gen`

## Requirements
- R1: While reset is high, and right after it is released, hsync, vsync, de and rgb are all 0. Reset also clears every register: both colours 0, bitmap empty, sprite position (0,0).
- R2: In full-rate mode (slow_mode=0) a line takes H_TOTAL = H_VIS+H_FP+H_SYNC+H_BP clocks, and the horizontal position rises by one each clock. de is high only for positions below H_VIS on visible lines. hsync is high for positions from H_VIS+H_FP up to, but not including, H_VIS+H_FP+H_SYNC. Each output shows the position the counter held one clock earlier. After reset the counter starts at position 0 of line 0.
- R3: A frame is V_TOTAL = V_VIS+V_FP+V_SYNC+V_BP lines. de is low on lines V_VIS and above. vsync is high on lines from V_VIS+V_FP up to, but not including, V_VIS+V_FP+V_SYNC.
- R4: With slow_mode=1 the horizontal position rises by SLOW_STEP each clock, so a line takes H_TOTAL/SLOW_STEP clocks. The same position windows hold, so hsync lasts H_SYNC/SLOW_STEP clocks.
- R5: Whenever de is low, rgb is 0.
- R6: Inside the visible area, a pixel not covered by a set sprite bit shows the background colour. The background colour is written at address 10.
- R7: The pixel at screen (h,v) lies in grid cell (h>>3, v>>3). If that cell is at (col,row) relative to the sprite's top-left cell, and bit col of bitmap row row is 1, the pixel shows the sprite colour. Bitmap row r is written at address r (0..7), and bit 0 is the leftmost column. The sprite colour is written at address 11. Both colours use the BBGGGRRR format.
- R8: A cell inside the sprite square whose bitmap bit is 0 shows the background colour (the sprite is transparent there).
- R9: Sprite X is written at address 8 and sprite Y at address 9. Each uses the low clog2(grid width) or clog2(grid height) bits of the data. A written position takes effect only at the clock where the beam moves from line V_VIS-1 into line V_VIS. Until then the sprite stays where it was.
- R10: Sprite cells that fall past the right edge or the bottom edge of the grid are not drawn, and they do not wrap to the opposite edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (40 MHz or 10 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| slow_mode | input | 1 | 1 = four screen pixels per clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Visible-area flag |
| rgb | output | 8 | Pixel colour, BBGGGRRR |

## Verification
The hardest case to reach from the ports is a position write that arrives part-way through a frame. For the rest of that frame the screen must keep the old sprite position. The new position must appear only after the switch into vertical blanking. To reach this case, the bench writes X in the middle of the visible lines and checks every pixel against a model that holds a pending position and an active position. The same full-screen sweep places the sprite at the bottom-right edge with a fully set bitmap. Any wrapped cell then shows up at the left or top edge of the grid. The sweep is also repeated in the four-pixel step mode.

// File: rtl/svg_pkg.sv
package svg_pkg;

    typedef logic [7:0] rgb_t;

    typedef enum logic [3:0] {
        ADDR_ROW0  = 4'd0,
        ADDR_SPR_X = 4'd8,
        ADDR_SPR_Y = 4'd9,
        ADDR_BACK  = 4'd10,
        ADDR_FORE  = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } beam_t;

    typedef struct packed {
        beam_t beam;
        rgb_t  rgb;
    } pix_t;

    function automatic rgb_t pick_colour(input logic de, input logic hit,
                                         input rgb_t fore, input rgb_t back);
        if (!de)
            return '0;
        return hit ? fore : back;
    endfunction

endpackage

// File: rtl/svg_beam.sv
module svg_beam
    import svg_pkg::*;
#(
    parameter int H_VIS     = 800,
    parameter int H_FP      = 40,
    parameter int H_SYNC    = 128,
    parameter int H_BP      = 88,
    parameter int V_VIS     = 600,
    parameter int V_FP      = 1,
    parameter int V_SYNC    = 4,
    parameter int V_BP      = 23,
    parameter int SLOW_STEP = 4,
    localparam int H_TOTAL  = H_VIS + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL  = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW       = $clog2(H_TOTAL),
    localparam int VW       = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slow_mode,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output beam_t         beam,
    output logic          vblank_start
);

    localparam int HS_LO = H_VIS + H_FP;
    localparam int HS_HI = H_VIS + H_FP + H_SYNC;
    localparam int VS_LO = V_VIS + V_FP;
    localparam int VS_HI = V_VIS + V_FP + V_SYNC;

    logic [HW:0]   h_sum;
    logic          line_end;
    logic [HW-1:0] h_nx;
    logic [VW-1:0] v_nx;

    always_comb begin
        h_sum    = {1'b0, h_pos} + (slow_mode ? (HW+1)'(SLOW_STEP) : (HW+1)'(1));
        line_end = h_sum >= (HW+1)'(H_TOTAL);
        h_nx     = line_end ? '0 : h_sum[HW-1:0];
        if (!line_end)
            v_nx = v_pos;
        else if (v_pos == VW'(V_TOTAL - 1))
            v_nx = '0;
        else
            v_nx = v_pos + VW'(1);
        vblank_start = line_end && (v_pos == VW'(V_VIS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_pos <= '0;
            v_pos <= '0;
        end else begin
            h_pos <= h_nx;
            v_pos <= v_nx;
        end
    end

    always_comb begin
        beam.de = (h_pos < HW'(H_VIS)) && (v_pos < VW'(V_VIS));
        beam.hs = (h_pos >= HW'(HS_LO)) && (h_pos < HW'(HS_HI));
        beam.vs = (v_pos >= VW'(VS_LO)) && (v_pos < VW'(VS_HI));
    end

endmodule

// File: rtl/svg_regfile.sv
module svg_regfile
    import svg_pkg::*;
#(
    parameter int SPR_N = 8,
    parameter int XW    = 7,
    parameter int YW    = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [3:0]                  wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic                        load_pos,
    output logic [SPR_N-1:0][SPR_N-1:0] bitmap,
    output rgb_t                        back_col,
    output rgb_t                        fore_col,
    output logic [XW-1:0]               act_x,
    output logic [YW-1:0]               act_y
);

    logic [XW-1:0] pend_x;
    logic [YW-1:0] pend_y;

    for (genvar r = 0; r < SPR_N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                bitmap[r] <= '0;
            else if (wr_en && wr_addr == (4'(ADDR_ROW0) + 4'(r)))
                bitmap[r] <= wr_data[SPR_N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            back_col <= '0;
            fore_col <= '0;
            pend_x   <= '0;
            pend_y   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_BACK:  back_col <= wr_data;
                ADDR_FORE:  fore_col <= wr_data;
                ADDR_SPR_X: pend_x   <= wr_data[XW-1:0];
                ADDR_SPR_Y: pend_y   <= wr_data[YW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_x <= '0;
            act_y <= '0;
        end else if (load_pos) begin
            act_x <= pend_x;
            act_y <= pend_y;
        end
    end

endmodule

// File: rtl/svg_sprite_hit.sv
module svg_sprite_hit #(
    parameter int SPR_N      = 8,
    parameter int SCALE_LOG2 = 3,
    parameter int HW         = 11,
    parameter int VW         = 10,
    parameter int XW         = 7,
    parameter int YW         = 7
) (
    input  logic [HW-1:0]               h_pos,
    input  logic [VW-1:0]               v_pos,
    input  logic [XW-1:0]               act_x,
    input  logic [YW-1:0]               act_y,
    input  logic [SPR_N-1:0][SPR_N-1:0] bitmap,
    output logic                        hit
);

    localparam int CW = $clog2(SPR_N);

    logic [HW-1:0] gx, ax, dx;
    logic [VW-1:0] gy, ay, dy;
    logic          in_x, in_y;

    always_comb begin
        gx   = h_pos >> SCALE_LOG2;
        gy   = v_pos >> SCALE_LOG2;
        ax   = HW'(act_x);
        ay   = VW'(act_y);
        dx   = gx - ax;
        dy   = gy - ay;
        in_x = (gx >= ax) && ({1'b0, gx} < ({1'b0, ax} + (HW+1)'(SPR_N)));
        in_y = (gy >= ay) && ({1'b0, gy} < ({1'b0, ay} + (VW+1)'(SPR_N)));
        hit  = in_x && in_y && bitmap[dy[CW-1:0]][dx[CW-1:0]];
    end

endmodule

// File: rtl/sprite_video_gen.sv
module sprite_video_gen
    import svg_pkg::*;
#(
    parameter int H_VIS      = 800,
    parameter int H_FP       = 40,
    parameter int H_SYNC     = 128,
    parameter int H_BP       = 88,
    parameter int V_VIS      = 600,
    parameter int V_FP       = 1,
    parameter int V_SYNC     = 4,
    parameter int V_BP       = 23,
    parameter int SCALE_LOG2 = 3,
    parameter int SPR_N      = 8,
    parameter int SLOW_STEP  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_mode,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       hsync,
    output logic       vsync,
    output logic       de,
    output logic [7:0] rgb
);

    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int GRID_W  = H_VIS >> SCALE_LOG2;
    localparam int GRID_H  = V_VIS >> SCALE_LOG2;
    localparam int XW      = $clog2(GRID_W);
    localparam int YW      = $clog2(GRID_H);

    logic [HW-1:0]               h_pos;
    logic [VW-1:0]               v_pos;
    beam_t                       beam;
    logic                        ld_pos;
    logic [SPR_N-1:0][SPR_N-1:0] bitmap;
    rgb_t                        back_col, fore_col;
    logic [XW-1:0]               act_x;
    logic [YW-1:0]               act_y;
    logic                        hit;
    pix_t                        pix_q;

    svg_beam #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .SLOW_STEP(SLOW_STEP)
    ) u_beam (
        .clk(clk), .rst(rst), .slow_mode(slow_mode),
        .h_pos(h_pos), .v_pos(v_pos), .beam(beam), .vblank_start(ld_pos)
    );

    svg_regfile #(.SPR_N(SPR_N), .XW(XW), .YW(YW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_pos(ld_pos), .bitmap(bitmap),
        .back_col(back_col), .fore_col(fore_col),
        .act_x(act_x), .act_y(act_y)
    );

    svg_sprite_hit #(
        .SPR_N(SPR_N), .SCALE_LOG2(SCALE_LOG2),
        .HW(HW), .VW(VW), .XW(XW), .YW(YW)
    ) u_hit (
        .h_pos(h_pos), .v_pos(v_pos), .act_x(act_x), .act_y(act_y),
        .bitmap(bitmap), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else begin
            pix_q.beam <= beam;
            pix_q.rgb  <= pick_colour(beam.de, hit, fore_col, back_col);
        end
    end

    assign hsync = pix_q.beam.hs;
    assign vsync = pix_q.beam.vs;
    assign de    = pix_q.beam.de;
    assign rgb   = pix_q.rgb;

endmodule

// File: rtl/svg_checker.sv
module svg_checker #(
    parameter int H_TOTAL = 1056,
    parameter int HW      = 11,
    parameter int XW      = 7,
    parameter int YW      = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic [7:0]    rgb,
    input logic [HW-1:0] h_pos,
    input logic          ld_pos,
    input logic [XW-1:0] act_x,
    input logic [YW-1:0] act_y
);

    // R5
    blank_black_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> rgb == 8'd0);

    // R2
    hsync_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hsync |-> !de);

    // R3
    vsync_blank_chk: assert property (@(posedge clk) disable iff (rst)
        vsync |-> !de);

    // R9
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_pos |=> ($stable(act_x) && $stable(act_y)));

    // R4
    h_range_chk: assert property (@(posedge clk) disable iff (rst)
        h_pos < HW'(H_TOTAL));

endmodule

bind sprite_video_gen svg_checker #(
    .H_TOTAL(H_TOTAL), .HW(HW), .XW(XW), .YW(YW)
) u_chk (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb),
    .h_pos(h_pos), .ld_pos(ld_pos), .act_x(act_x), .act_y(act_y)
);

// File: tb/sprite_video_gen_test.sv
module sprite_video_gen_test;

    localparam int HV = 64, HF = 4, HS = 8, HB = 4;
    localparam int VV = 48, VF = 1, VS = 2, VB = 2;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int GW = HV / 8, GH = VV / 8;
    localparam int XM = (1 << $clog2(GW)) - 1;
    localparam int YM = (1 << $clog2(GH)) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hsync, vsync, de;
    logic [7:0] rgb;

    int checks = 0;
    int errors = 0;

    int hp = 0, vp = 0, ax = 0, ay = 0, px = 0, py = 0;
    logic [7:0] bg = '0, fg = '0;
    logic [7:0] bm [8];

    always #10 clk = ~clk;

    sprite_video_gen #(
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .SCALE_LOG2(3), .SPR_N(8), .SLOW_STEP(4)
    ) uut (
        .clk(clk), .rst(rst), .slow_mode(slow_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at h=%0d v=%0d: got %0h expected %0h", tag, hp, vp, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d);
        int php, pvp, gx, gy;
        logic evis, ehs, evs, inbox, bitv;
        logic [7:0] ergb;
        string tag, htag;
        php = hp; pvp = vp;
        evis = (hp < HV) && (vp < VV);
        ehs  = (hp >= HV + HF) && (hp < HV + HF + HS);
        evs  = (vp >= VV + VF) && (vp < VV + VF + VS);
        gx = hp / 8; gy = vp / 8;
        inbox = (gx >= ax) && (gx < ax + 8) && (gy >= ay) && (gy < ay + 8);
        bitv  = inbox ? bm[gy - ay][gx - ax] : 1'b0;
        ergb  = !evis ? 8'd0 : (bitv ? fg : bg);
        if (!evis)                          tag = "R5";
        else if (ax + 8 > GW || ay + 8 > GH) tag = "R10";
        else if (ax != px || ay != py)      tag = "R9";
        else if (bitv)                      tag = "R7";
        else if (inbox)                     tag = "R8";
        else                                tag = "R6";
        htag = slow_mode ? "R4" : "R2";
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        hp = hp + (slow_mode ? 4 : 1);
        if (hp >= HT) begin
            hp = 0;
            if (vp == VV - 1) begin ax = px; ay = py; end
            vp = (vp == VT - 1) ? 0 : vp + 1;
        end
        if (we) begin
            if (a < 8)        bm[a] = d;
            else if (a == 8)  px = d & XM;
            else if (a == 9)  py = d & YM;
            else if (a == 10) bg = d;
            else if (a == 11) fg = d;
        end
        @(negedge clk);
        wr_en = 1'b0;
        begin
            int sh, sv;
            sh = hp; sv = vp;
            hp = php; vp = pvp;
            check(htag, hsync, ehs);
            check("R3", vsync, evs);
            check(htag, de, evis);
            check(tag, rgb, ergb);
            hp = sh; vp = sv;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 8'd0);
    endtask

    task automatic to_frame_start();
        do step(1'b0, 4'd0, 8'd0); while (!(hp == 0 && vp == 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) bm[i] = '0;
        repeat (3) @(posedge clk);
        check("R1", {hsync, vsync, de, rgb}, 0);
        @(negedge clk);
        rst = 1'b0;
        check("R1", {hsync, vsync, de, rgb}, 0);
        // R1 / R6: empty bitmap, background still 0 after reset
        idle(HT * 2);
        to_frame_start();
        // R6 / R2 / R3: background only, one full frame
        step(1'b1, 4'd10, 8'h5A);
        to_frame_start();
        // R7 / R8: bitmap rows, sprite colour, position (X=2, Y=1)
        step(1'b1, 4'd0, 8'hA5);
        step(1'b1, 4'd1, 8'h3C);
        step(1'b1, 4'd2, 8'h81);
        step(1'b1, 4'd3, 8'h0F);
        step(1'b1, 4'd11, 8'hE7);
        step(1'b1, 4'd8, 8'd2);
        step(1'b1, 4'd9, 8'd1);
        to_frame_start();
        to_frame_start();
        // R9: move X in mid-frame; old position stays until vertical blanking
        idle(HT * 20);
        step(1'b1, 4'd8, 8'd0);
        step(1'b1, 4'd9, 8'd0);
        to_frame_start();
        to_frame_start();
        // R10: full bitmap at bottom-right, clipped, no wrap
        for (int r = 0; r < 8; r++) step(1'b1, 4'(r), 8'hFF);
        step(1'b1, 4'd8, 8'd6);
        step(1'b1, 4'd9, 8'd4);
        to_frame_start();
        to_frame_start();
        // R4: four-pixel step mode
        slow_mode = 1'b1;
        step(1'b1, 4'd0, 8'h18);
        step(1'b1, 4'd8, 8'd1);
        step(1'b1, 4'd9, 8'd2);
        step(1'b1, 4'd10, 8'h12);
        to_frame_start();
        to_frame_start();
        idle((HT / 4) * 10);
        step(1'b1, 4'd8, 8'd7);
        to_frame_start();
        to_frame_start();
        // R2: back to full rate
        slow_mode = 1'b0;
        to_frame_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule